// File: doc/BRIEF.md
# Two-Line Interrupt Router

This block sits between a USB function core and an interrupt controller. The core reports events as single-cycle pulses, one wire per source. The block latches each pulse into a flag bit and gates each flag with its own enable bit. It then sends every enabled, pending source to one of two interrupt lines, chosen by the source's own select bit. The CPU sees three byte-wide registers per group (flags, enables, selects) for two groups of sources. It clears a flag by writing a one to that flag's bit.

Group 0 holds eight sources. From bit 7 down to bit 0 they are: bus reset, EP1 FIFO full, EP2 transfer request, EP2 FIFO empty, setup receive complete, EP0-out receive complete, EP0-in transfer request and EP0-in transmit complete. Group 1 holds three sources: EP3 transfer request at bit 2, EP3 transmit complete at bit 1 and VBUS connection change at bit 0. Bits 7 to 3 of group 1 do not exist. Both lines are level outputs. A one-hot grant output names the line to serve first, and line 0 is preferred when both lines are active.

Top module: `usb_irq_router`

## Requirements
- R1: After reset, all flags and both enable registers read 0x00, the group 0 select register reads 0x00, the group 1 select register reads 0x07, and both lines and the grant are low.
- R2: An event pulse on a source sets its flag at the next clock edge, and the flag stays set until the CPU clears it. Event bits 7:0 belong to group 0 and bits 15:8 belong to group 1.
- R3: A write to a flag register (address 0 for group 0, address 1 for group 1) clears each flag whose wdata bit is 1. Flags whose wdata bit is 0 keep their value.
- R4: When a set pulse and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R5: A source drives a line only while both its flag and its enable bit are 1. The enable registers are at address 2 (group 0) and address 3 (group 1).
- R6: An enabled, pending source drives line 0 when its select bit is 0 and line 1 when its select bit is 1. The select registers are at address 4 (group 0) and address 5 (group 1). Each line is the OR of the sources routed to it.
- R7: grant[0] is high whenever line 0 is high. grant[1] is high only when line 1 is high and line 0 is low. The grant is never 2'b11.
- R8: Group 1 bits 7:3 read as 0 in its flag, enable and select registers. Writes to those bits are ignored, and event pulses on event bits 15:11 set nothing.
- R9: Addresses 6 and 7 read as 0, and writes to them change no register.
- R10: Enable and select registers read back the last value written to their valid bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 16 | One-cycle event pulses; [7:0] group 0, [15:8] group 1 |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| irq_line0 | output | 1 | Interrupt line 0 (level) |
| irq_line1 | output | 1 | Interrupt line 1 (level) |
| grant | output | 2 | One-hot grant, line 0 preferred |

## Verification
The bench targets four kinds of fault:

- **Set and clear in the same cycle.** A design that let the clear win would show the flag dropping to zero.
- **Moving a source between lines and stacking sources on both lines.** A design with inverted routing, or with an arbiter that prefers line 1, would show the wrong line or a grant of 2'b10 while both lines are high.
- **The missing upper bits of group 1.** A design that stored those bits would read back 0xFF instead of 0x07.
- **The unused addresses.** A design that aliased addresses 6 and 7 onto a real register would return nonzero data there, or would corrupt the group 0 enable value that is read afterwards.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int unsigned GRP_CNT = 2;

   typedef enum logic [2:0] {
      RA_FLAG0 = 3'd0,
      RA_FLAG1 = 3'd1,
      RA_EN0   = 3'd2,
      RA_EN1   = 3'd3,
      RA_SEL0  = 3'd4,
      RA_SEL1  = 3'd5
   } reg_addr_e;

   localparam int unsigned FIRST_UNMAPPED = 6;

   typedef enum logic [1:0] {
      GNT_NONE  = 2'b00,
      GNT_LINE0 = 2'b01,
      GNT_LINE1 = 2'b10
   } grant_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned   W    = 8,
   parameter logic [W-1:0]  MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_pulse,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] flags
);
   if (W < 1) begin : g_bad_w
      $error("irq_flag_bank: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (MASK[b]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_pulse[b] | (q & ~clr_bits[b]);
         end
         assign flags[b] = q;
      end else begin : g_rsvd
         assign flags[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
   parameter int unsigned   W        = 8,
   parameter logic [W-1:0]  MASK     = '1,
   parameter logic [W-1:0]  RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if ((RST_VAL & ~MASK) != '0) begin : g_bad_rst
      $error("irq_cfg_reg: reset value sets a reserved bit");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (MASK[b]) begin : g_live
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= RST_VAL[b];
            else if (we) r <= wdata[b];
         end
         assign q[b] = r;
      end else begin : g_rsvd
         assign q[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_line_arbiter.sv
module irq_line_arbiter #(
   parameter int unsigned N           = 16,
   parameter bit          LINE0_FIRST = 1'b1
) (
   input  logic [N-1:0] pend,
   input  logic [N-1:0] route,
   output logic         line0,
   output logic         line1,
   output logic [1:0]   grant
);
   import irq_route_pkg::*;

   if (N < 1) begin : g_bad_n
      $error("irq_line_arbiter: N must be at least 1");
   end

   assign line0 = |(pend & ~route);
   assign line1 = |(pend & route);

   if (LINE0_FIRST) begin : g_prefer0
      always_comb begin
         if (line0)      grant = GNT_LINE0;
         else if (line1) grant = GNT_LINE1;
         else            grant = GNT_NONE;
      end
   end else begin : g_prefer1
      always_comb begin
         if (line1)      grant = GNT_LINE1;
         else if (line0) grant = GNT_LINE0;
         else            grant = GNT_NONE;
      end
   end
endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router #(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ADDR_W      = 3,
   parameter logic [DATA_W-1:0] G0_MASK     = 8'hFF,
   parameter logic [DATA_W-1:0] G1_MASK     = 8'h07,
   parameter logic [DATA_W-1:0] G0_EN_RST   = 8'h00,
   parameter logic [DATA_W-1:0] G1_EN_RST   = 8'h00,
   parameter logic [DATA_W-1:0] G0_SEL_RST  = 8'h00,
   parameter logic [DATA_W-1:0] G1_SEL_RST  = 8'h07,
   parameter bit                LINE0_FIRST = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [irq_route_pkg::GRP_CNT*DATA_W-1:0] evt,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic                             irq_line0,
   output logic                             irq_line1,
   output logic [1:0]                       grant
);
   import irq_route_pkg::*;

   localparam int unsigned TOT_W = GRP_CNT * DATA_W;
   localparam logic [TOT_W-1:0] MASK_ALL   = {G1_MASK, G0_MASK};
   localparam logic [TOT_W-1:0] EN_RST_ALL = {G1_EN_RST, G0_EN_RST};
   localparam logic [TOT_W-1:0] SEL_RST_ALL = {G1_SEL_RST, G0_SEL_RST};

   if (ADDR_W < 3) begin : g_bad_addr
      $error("usb_irq_router: ADDR_W must be at least 3");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("usb_irq_router: DATA_W must be at least 1");
   end

   logic [TOT_W-1:0] flag_all;
   logic [TOT_W-1:0] en_all;
   logic [TOT_W-1:0] sel_all;
   logic             addr_mapped;
   logic [2:0]       addr_lo;

   assign addr_mapped = (addr < ADDR_W'(FIRST_UNMAPPED));
   assign addr_lo     = addr[2:0];

   for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
      logic hit_flag, hit_en, hit_sel;
      logic [DATA_W-1:0] clr;

      assign hit_flag = wr_en && addr_mapped && (addr_lo == 3'(RA_FLAG0 + g));
      assign hit_en   = wr_en && addr_mapped && (addr_lo == 3'(RA_EN0 + g));
      assign hit_sel  = wr_en && addr_mapped && (addr_lo == 3'(RA_SEL0 + g));
      assign clr      = hit_flag ? wdata : '0;

      irq_flag_bank #(
         .W    (DATA_W),
         .MASK (MASK_ALL[g*DATA_W +: DATA_W])
      ) u_flags (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_pulse (evt[g*DATA_W +: DATA_W]),
         .clr_bits  (clr),
         .flags     (flag_all[g*DATA_W +: DATA_W])
      );

      irq_cfg_reg #(
         .W       (DATA_W),
         .MASK    (MASK_ALL[g*DATA_W +: DATA_W]),
         .RST_VAL (EN_RST_ALL[g*DATA_W +: DATA_W])
      ) u_en (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (hit_en),
         .wdata (wdata),
         .q     (en_all[g*DATA_W +: DATA_W])
      );

      irq_cfg_reg #(
         .W       (DATA_W),
         .MASK    (MASK_ALL[g*DATA_W +: DATA_W]),
         .RST_VAL (SEL_RST_ALL[g*DATA_W +: DATA_W])
      ) u_sel (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (hit_sel),
         .wdata (wdata),
         .q     (sel_all[g*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      rdata = '0;
      if (addr_mapped) begin
         case (addr_lo[2:1])
            2'd0:    rdata = addr_lo[0] ? flag_all[DATA_W +: DATA_W] : flag_all[0 +: DATA_W];
            2'd1:    rdata = addr_lo[0] ? en_all[DATA_W +: DATA_W]   : en_all[0 +: DATA_W];
            2'd2:    rdata = addr_lo[0] ? sel_all[DATA_W +: DATA_W]  : sel_all[0 +: DATA_W];
            default: rdata = '0;
         endcase
      end
   end

   irq_line_arbiter #(
      .N           (TOT_W),
      .LINE0_FIRST (LINE0_FIRST)
   ) u_arb (
      .pend  (flag_all & en_all),
      .route (sel_all),
      .line0 (irq_line0),
      .line1 (irq_line1),
      .grant (grant)
   );
endmodule

// File: rtl/usb_irq_router_chk.sv
module usb_irq_router_chk #(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ADDR_W      = 3,
   parameter int unsigned       TOT_W       = 16,
   parameter logic [TOT_W-1:0]  MASK_ALL    = 16'h07FF,
   parameter bit                LINE0_FIRST = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TOT_W-1:0]  evt,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [TOT_W-1:0]  flag_all,
   input logic [TOT_W-1:0]  en_all,
   input logic [TOT_W-1:0]  sel_all,
   input logic              irq_line0,
   input logic              irq_line1,
   input logic [1:0]        grant
);
   localparam logic [DATA_W-1:0] G1_MASK = MASK_ALL[DATA_W +: DATA_W];

   // R2 and R4: a pulse always leaves its (valid) flag set, whatever was written
   a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_all & $past(evt & MASK_ALL)) == $past(evt & MASK_ALL)));

   // R3: write-one-to-clear on group 0 flags without a competing pulse
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0) |=>
         ((flag_all[DATA_W-1:0] & $past(wdata & ~evt[DATA_W-1:0])) == '0));

   // R5: no pending enabled source means both lines are quiet
   a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_all & en_all) == '0) |-> (!irq_line0 && !irq_line1));

   // R6: each line is backed by a source routed to it
   a_r6_line1_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line1 |-> (|(flag_all & en_all & sel_all)));
   a_r6_line0_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line0 |-> (|(flag_all & en_all & ~sel_all)));

   // R7: grant is one-hot when any line is active and favours the configured line
   a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r7_any: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line0 || irq_line1) |-> (grant != 2'b00));
   a_r7_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line0 && irq_line1) |-> (grant == (LINE0_FIRST ? 2'b01 : 2'b10)));

   // R8: odd (group 1) mapped addresses never return reserved bits
   a_r8_rsvd_read: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[0] && addr < ADDR_W'(6)) |-> ((rdata & ~G1_MASK) == '0));

   // R9: unmapped addresses read zero
   a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= ADDR_W'(6)) |-> (rdata == '0));
endmodule

bind usb_irq_router usb_irq_router_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .TOT_W       (TOT_W),
   .MASK_ALL    (MASK_ALL),
   .LINE0_FIRST (LINE0_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt       (evt),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .flag_all  (flag_all),
   .en_all    (en_all),
   .sel_all   (sel_all),
   .irq_line0 (irq_line0),
   .irq_line1 (irq_line1),
   .grant     (grant)
);

// File: tb/sim_usb_irq_router.sv
module sim_usb_irq_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq_line0, irq_line1;
   logic [1:0]  grant;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit         is_line;
      logic [7:0] exp;
      string      req;
   } exp_item_t;

   exp_item_t sb[$];

   always #5 clk = ~clk;

   usb_irq_router u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .irq_line0 (irq_line0),
      .irq_line1 (irq_line1),
      .grant     (grant)
   );

   // monitor: compares queued expectations away from the clock edge
   always @(negedge clk) begin
      #2;
      while (sb.size() > 0) begin
         exp_item_t it;
         logic [7:0] act;
         it  = sb.pop_front();
         act = it.is_line ? {4'b0, grant, irq_line1, irq_line0} : rdata;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", it.req,
                     it.is_line ? "grant/lines" : "rdata", act, it.exp);
         end
      end
   end

   task automatic do_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic pulse(input logic [15:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string req);
      exp_item_t it;
      @(negedge clk);
      addr = a;
      it.is_line = 1'b0; it.exp = e; it.req = req;
      sb.push_back(it);
   endtask

   // expected word is {grant[1:0], line1, line0}
   task automatic exp_lines(input logic [3:0] e, input string req);
      exp_item_t it;
      @(negedge clk);
      it.is_line = 1'b1; it.exp = {4'b0, e}; it.req = req;
      sb.push_back(it);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      exp_rd(3'd0, 8'h00, "R1");
      exp_rd(3'd1, 8'h00, "R1");
      exp_rd(3'd2, 8'h00, "R1");
      exp_rd(3'd3, 8'h00, "R1");
      exp_rd(3'd4, 8'h00, "R1");
      exp_rd(3'd5, 8'h07, "R1");
      exp_lines(4'b0000, "R1");

      // R2 pulses set flags; R5 nothing enabled yet
      pulse(16'h0081);
      exp_rd(3'd0, 8'h81, "R2");
      exp_lines(4'b0000, "R5");

      // R6/R7 source 0 to line 0
      do_write(3'd2, 8'h01);
      exp_lines(4'b0101, "R6");
      // R6 reroute to line 1
      do_write(3'd4, 8'h01);
      exp_lines(4'b1010, "R6");
      exp_rd(3'd2, 8'h01, "R10");
      exp_rd(3'd4, 8'h01, "R10");

      // R7 both lines active, line 0 wins
      do_write(3'd2, 8'h81);
      exp_lines(4'b0111, "R7");

      // R3 clear bit 0 only
      do_write(3'd0, 8'h01);
      exp_rd(3'd0, 8'h80, "R3");
      exp_lines(4'b0101, "R3");
      do_write(3'd0, 8'h00);
      exp_rd(3'd0, 8'h80, "R3");

      // R4 set and clear collide on bit 7
      @(negedge clk);
      evt = 16'h0080; wr_en = 1'b1; addr = 3'd0; wdata = 8'h80;
      @(negedge clk);
      evt = '0; wr_en = 1'b0; wdata = '0;
      exp_rd(3'd0, 8'h80, "R4");
      do_write(3'd0, 8'h80);
      exp_rd(3'd0, 8'h00, "R3");
      exp_lines(4'b0000, "R5");

      // R8 group 1 reserved bits
      pulse(16'hFF00);
      exp_rd(3'd1, 8'h07, "R8");
      do_write(3'd3, 8'hFF);
      exp_rd(3'd3, 8'h07, "R8");
      exp_lines(4'b1010, "R6");
      do_write(3'd5, 8'hF8);
      exp_rd(3'd5, 8'h00, "R8");
      exp_lines(4'b0101, "R6");
      do_write(3'd1, 8'hFF);
      exp_rd(3'd1, 8'h00, "R3");
      exp_lines(4'b0000, "R5");

      // R9 unmapped addresses
      do_write(3'd6, 8'hFF);
      do_write(3'd7, 8'hFF);
      exp_rd(3'd6, 8'h00, "R9");
      exp_rd(3'd7, 8'h00, "R9");
      exp_rd(3'd2, 8'h81, "R9");
      exp_rd(3'd4, 8'h01, "R9");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule